// File: doc/BRIEF.md
# Cache Capacity Allocation Controller

This block holds the cache-capacity allocation table for a shared cache. Each resource-control ID owns a bitmask of capacity blocks, and each supported access type (data or code) has its own mask. Software reaches the block through a simple register bus that carries 8-byte or 4-byte accesses. A 4-byte access touches one half of a 64-bit register.

To act on the table, software writes an operation word into the control register. The block then validates the ID and the access type. It either stores the staged mask into the table or loads the stored mask back into the staging register. It posts a status code and clears its busy flag in the following cycle.

Register words sit on 8-byte boundaries. Word 0 is the control register. Words 1 to SLOTS hold the staging mask, where SLOTS is ceil(NCBLKS/64). The next word is a capacity-unit register, which reads as zero. Every address above that reads as zero and ignores writes.

Top module: `cap_alloc_ctrl`

## Requirements
- R1: The control word holds op in [4:0], access type in [7:5], type-valid in [8], ID in [23:12], status in [38:32] and busy in [39]. A write to its low half while busy is 0 sets busy at the next edge. Busy reads as 1 for exactly one cycle, and status is posted when busy clears.
- R2: Op 1 (store) with status 1 (success) writes the staged mask into the entry for the request's ID and access type. Access type 0 is data and type 1 is code, and the two entries are independent. When type-valid is 0, the access-type field is ignored and type 0 is used.
- R3: An ID of NRCID or above completes with status 3. It changes neither the table nor the staging register. This check takes precedence over every other check.
- R4: With type-valid set, an unsupported access type (2 to 7 by default) completes with status 4 and changes no state.
- R5: An op value of 0 or of 4 to 31 completes with status 2 and changes no state.
- R6: A store whose staged mask is zero, or has any bit set at position NCBLKS or above, completes with status 5 and leaves the table unchanged.
- R7: Op 2 (load) completes with status 1 and copies the stored mask, zero-extended, into the staging register.
- R8: Op 3 (flush) completes with status 1 and changes neither the table nor the staging register.
- R9: A write to the control register while busy is 1 is ignored.
- R10: With bus_wide at 0, an access moves 32 bits on data lanes [31:0], and address bit 2 selects the upper half. A 4-byte write to the upper half of the control register is ignored, and a 4-byte write to its lower half starts an operation.
- R11: After reset, busy, status, the control fields and the staging register are all 0. ID 0 owns all NCBLKS blocks for both access types.
- R12: The capacity-unit word and all higher addresses read as zero and ignore writes.
- R13: When a bus write to the staging register falls in the same cycle in which a load completes, the loaded mask is what remains in the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data; 4-byte writes use [31:0] |
| bus_rdata | output | 64 | Read data, registered one cycle after the read |

## Verification
Two functions can land in the same cycle. One is the completion of a load operation, which writes the staging register. The other is a bus write to that same register, or a second write to the control register.

The bench provokes both on purpose. It issues the second bus access back to back with the operation that starts the load. It then judges the result by reading the staging register and the control fields afterwards: the load result must win, and the second control write must leave no trace.

// File: rtl/cap_alloc_pkg.sv
// Package: shared field codes and the request type of the capacity allocation controller.
// Assumes: op and status codes match the register layout in the brief.
package cap_alloc_pkg;
    localparam logic [4:0] OP_STORE = 5'd1;
    localparam logic [4:0] OP_LOAD  = 5'd2;
    localparam logic [4:0] OP_FLUSH = 5'd3;

    localparam logic [6:0] ST_NONE     = 7'd0;
    localparam logic [6:0] ST_OK       = 7'd1;
    localparam logic [6:0] ST_BAD_OP   = 7'd2;
    localparam logic [6:0] ST_BAD_RCID = 7'd3;
    localparam logic [6:0] ST_BAD_AT   = 7'd4;
    localparam logic [6:0] ST_BAD_MASK = 7'd5;

    typedef struct packed {
        logic [11:0] rcid;
        logic        atv;
        logic [2:0]  at;
        logic [4:0]  op;
    } ctl_req_t;
endpackage

// File: rtl/cap_alloc_table.sv
// Module: mask storage, one NCBLKS-bit entry per (ID, access type) pair.
// Assumes: entry index = ID*2 + type; the caller only writes valid indices.
module cap_alloc_table #(
    parameter int NCBLKS  = 16,
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NCBLKS-1:0]           wr_mask,
    output logic [NCBLKS-1:0]           rd_mask,
    output logic [ENTRIES*NCBLKS-1:0]   flat
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [NCBLKS-1:0] q;
        // Entry register: ID 0 owns every block at reset, others start empty.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= (e < 2) ? {NCBLKS{1'b1}} : {NCBLKS{1'b0}};
            else if (wr_en && idx == IDX_W'(e))
                q <= wr_mask;
        end
        assign flat[e*NCBLKS +: NCBLKS] = q;
    end

    // Read port: selects the addressed entry.
    always_comb rd_mask = flat[int'(idx)*NCBLKS +: NCBLKS];
endmodule

// File: rtl/cap_alloc_check.sv
// Module: validates the latched request and decides the action and status.
// Assumes: checks run in order ID, access type, op, then mask.
module cap_alloc_check
    import cap_alloc_pkg::*;
#(
    parameter int          NCBLKS = 16,
    parameter int          NRCID  = 16,
    parameter int          MASK_W = 64,
    parameter int          IDX_W  = 5,
    parameter logic [7:0]  AT_SUP = 8'h03
) (
    input  ctl_req_t            req,
    input  logic [MASK_W-1:0]   stage,
    output logic [6:0]          status,
    output logic                store,
    output logic                load,
    output logic [IDX_W-1:0]    idx
);
    localparam logic [12:0]       RCID_LIM = 13'(NRCID);
    localparam logic [MASK_W-1:0] LEGAL    = ~({MASK_W{1'b1}} << NCBLKS);

    logic at_eff;

    // Effective type: field used only when flagged valid.
    always_comb begin
        at_eff = req.atv ? req.at[0] : 1'b0;
        idx    = IDX_W'({req.rcid, at_eff});
    end

    // Ordered validation and action decode.
    always_comb begin
        status = ST_OK;
        store  = 1'b0;
        load   = 1'b0;
        if ({1'b0, req.rcid} >= RCID_LIM) begin
            status = ST_BAD_RCID;
        end else if (req.atv && !AT_SUP[req.at]) begin
            status = ST_BAD_AT;
        end else begin
            case (req.op)
                OP_STORE: begin
                    if (stage == '0 || (stage & ~LEGAL) != '0)
                        status = ST_BAD_MASK;
                    else
                        store = 1'b1;
                end
                OP_LOAD:  load = 1'b1;
                OP_FLUSH: ;
                default:  status = ST_BAD_OP;
            endcase
        end
    end
endmodule

// File: rtl/cap_alloc_bus.sv
// Module: register bus decode, control/status registers, staging mask and read data.
// Assumes: 8-byte accesses are aligned; 4-byte accesses use lanes [31:0].
module cap_alloc_bus
    import cap_alloc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOTS  = 1,
    parameter int MASK_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic                bus_wide,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic [63:0]         bus_rdata,
    output ctl_req_t            req,
    output logic                busy,
    output logic [6:0]          status,
    output logic [MASK_W-1:0]   stage,
    input  logic [6:0]          done_status,
    input  logic                load_en,
    input  logic [MASK_W-1:0]   load_mask
);
    localparam int WORD_W = ADDR_W - 3;

    logic [WORD_W-1:0] word;
    logic              wr_lo, wr_hi, accept;
    logic [31:0]       lo_data, hi_data;
    logic [63:0]       ctl64, rd_word;

    // Lane and word decode for the current access.
    always_comb begin
        word    = bus_addr[ADDR_W-1:3];
        wr_lo   = bus_en && bus_we && (bus_wide || !bus_addr[2]);
        wr_hi   = bus_en && bus_we && (bus_wide || bus_addr[2]);
        lo_data = bus_wdata[31:0];
        hi_data = bus_wide ? bus_wdata[63:32] : bus_wdata[31:0];
        accept  = wr_lo && word == '0 && !busy;
    end

    // Control fields: latched only by an accepted low-half write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= '0;
        else if (accept)
            req <= '{rcid: lo_data[23:12], atv: lo_data[8], at: lo_data[7:5], op: lo_data[4:0]};
    end

    // Busy and status: one execute cycle, then post the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            status <= ST_NONE;
        end else if (busy) begin
            busy   <= 1'b0;
            status <= done_status;
        end else if (accept) begin
            busy <= 1'b1;
        end
    end

    // Staging mask: bus halves, overridden by a completing load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (load_en) begin
            stage <= load_mask;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (word == WORD_W'(s + 1)) begin
                    if (wr_lo) stage[s*64 +: 32]      <= lo_data;
                    if (wr_hi) stage[s*64 + 32 +: 32] <= hi_data;
                end
            end
        end
    end

    // Read mux: control, staging slots, zero elsewhere.
    always_comb begin
        ctl64   = {24'b0, busy, status, 8'b0, req.rcid, 3'b0, req.atv, req.at, req.op};
        rd_word = '0;
        if (word == '0) rd_word = ctl64;
        for (int s = 0; s < SLOTS; s++) begin
            if (word == WORD_W'(s + 1)) rd_word = stage[s*64 +: 64];
        end
    end

    // Read data register: captured on a read request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_en && !bus_we)
            bus_rdata <= bus_wide ? rd_word
                                  : {32'b0, bus_addr[2] ? rd_word[63:32] : rd_word[31:0]};
    end
endmodule

// File: rtl/cap_alloc_ctrl.sv
// Module: top of the capacity allocation controller; joins bus, validator and table.
// Assumes: NRCID >= 2, AT_SUP uses only bits 1:0, ADDR_W large enough for all words.
module cap_alloc_ctrl
    import cap_alloc_pkg::*;
#(
    parameter int          NCBLKS = 16,
    parameter int          NRCID  = 16,
    parameter logic [7:0]  AT_SUP = 8'h03,
    parameter int          ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata
);
    localparam int SLOTS   = (NCBLKS + 63) / 64;
    localparam int MASK_W  = 64 * SLOTS;
    localparam int ENTRIES = 2 * NRCID;
    localparam int IDX_W   = $clog2(ENTRIES);

    ctl_req_t                  req;
    logic                      busy, store, load;
    logic [6:0]                status, chk_status;
    logic [MASK_W-1:0]         stage;
    logic [IDX_W-1:0]          idx;
    logic [NCBLKS-1:0]         rd_mask;
    logic [ENTRIES*NCBLKS-1:0] tbl_flat;

    cap_alloc_bus #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .MASK_W(MASK_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .req(req), .busy(busy), .status(status),
        .stage(stage), .done_status(chk_status), .load_en(busy && load),
        .load_mask(MASK_W'(rd_mask))
    );

    cap_alloc_check #(.NCBLKS(NCBLKS), .NRCID(NRCID), .MASK_W(MASK_W),
                      .IDX_W(IDX_W), .AT_SUP(AT_SUP)) u_check (
        .req(req), .stage(stage), .status(chk_status), .store(store),
        .load(load), .idx(idx)
    );

    cap_alloc_table #(.NCBLKS(NCBLKS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(busy && store), .idx(idx),
        .wr_mask(stage[NCBLKS-1:0]), .rd_mask(rd_mask), .flat(tbl_flat)
    );
endmodule

// File: rtl/cap_alloc_sva.sv
// Module: property checker for cap_alloc_ctrl, attached by bind.
// Assumes: observes top ports plus latched request, busy, status and the table image.
module cap_alloc_sva
    import cap_alloc_pkg::*;
#(
    parameter int NRCID  = 16,
    parameter int TBL_W  = 512,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input ctl_req_t          req,
    input logic              busy,
    input logic [6:0]        status,
    input logic [TBL_W-1:0]  tbl_flat
);
    logic ctl_wr;
    assign ctl_wr = bus_en && bus_we && (bus_wide || !bus_addr[2]) &&
                    bus_addr[ADDR_W-1:3] == '0;

    a_r1_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !busy |=> busy);

    a_r1_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy && status != ST_NONE);

    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && busy |=> $stable(req));

    a_r3_rcid_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        busy && int'(req.rcid) >= NRCID |=> status == ST_BAD_RCID && $stable(tbl_flat));

    a_r8_flush_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req.op == OP_FLUSH |=> $stable(tbl_flat));
endmodule

bind cap_alloc_ctrl cap_alloc_sva #(.NRCID(NRCID), .TBL_W(ENTRIES*NCBLKS), .ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .req(req), .busy(busy), .status(status), .tbl_flat(tbl_flat)
);

// File: tb/test_cap_alloc_ctrl.sv
// Bench: sweeps the default configuration (16 IDs, 16 blocks, types 0 and 1).
module test_cap_alloc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] d;
    logic [15:0] exp_tbl [16][2];
    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cap_alloc_ctrl i_cap_alloc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] mval(int r, int a);
        logic [15:0] v = 16'((r * 16'h0961) + (a * 16'h02D3) + 16'h0101);
        return (v == 0) ? 16'h0001 : v;
    endfunction

    function automatic logic [63:0] ctl(int op, int at, bit atv, int rcid);
        return {40'b0, 12'(rcid), 3'b0, atv, 3'(at), 5'(op)};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] v, bit wide);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = v; bus_wide = wide;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(logic [11:0] a, bit wide, output logic [63:0] v);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a; bus_wide = wide;
        @(negedge clk);
        bus_en = 0;
        v = bus_rdata;
    endtask

    // Issue an operation; returns the posted status (read from the upper half).
    task automatic op(int o, int at, bit atv, int rcid, output logic [6:0] st);
        logic [63:0] v;
        wr(12'h000, ctl(o, at, atv, rcid), 1);
        rd(12'h004, 0, v);
        st = v[6:0];
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        logic [6:0] st;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R11: reset state
        rd(12'h000, 1, d); chk("R11 ctl reset", d, 64'h0);
        rd(12'h008, 1, d); chk("R11 staging reset", d, 64'h0);
        for (int a = 0; a < 2; a++) begin
            op(2, a, 1, 0, st); chk("R11 load status", 64'(st), 64'd1);
            rd(12'h008, 1, d); chk("R11 id0 owns all", d, 64'hFFFF);
        end

        // R1: busy visible during the execute cycle
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = ctl(3, 0, 1, 1); bus_wide = 1;
        @(negedge clk);
        bus_we = 0; bus_addr = 12'h004; bus_wide = 0;
        @(negedge clk);
        bus_en = 0;
        chk("R1 busy during execute", 64'(bus_rdata[7]), 64'd1);
        rd(12'h004, 0, d); chk("R1 busy cleared, status", d, 64'h01);
        rd(12'h000, 0, d); chk("R1 fields readback", d, ctl(3, 0, 1, 1));

        // R2: store all pairs, R7: load them back
        for (int r = 0; r < 16; r++)
            for (int a = 0; a < 2; a++) begin
                wr(12'h008, 64'(mval(r, a)), 1);
                op(1, a, 1, r, st); chk("R2 store status", 64'(st), 64'd1);
                exp_tbl[r][a] = mval(r, a);
            end
        for (int r = 0; r < 16; r++)
            for (int a = 0; a < 2; a++) begin
                op(2, a, 1, r, st); chk("R7 load status", 64'(st), 64'd1);
                rd(12'h008, 1, d); chk("R7 load value", d, 64'(exp_tbl[r][a]));
            end

        // R2: type-valid clear uses type 0
        wr(12'h008, 64'h0F0F, 1);
        op(1, 1, 0, 3, st); chk("R2 atv0 store", 64'(st), 64'd1);
        exp_tbl[3][0] = 16'h0F0F;
        op(2, 0, 1, 3, st); rd(12'h008, 1, d); chk("R2 atv0 hit type0", d, 64'h0F0F);
        op(2, 1, 1, 3, st); rd(12'h008, 1, d); chk("R2 type1 untouched", d, 64'(exp_tbl[3][1]));

        // R3: invalid ID wins over bad type and leaves staging and table alone
        wr(12'h008, 64'h1234, 1);
        for (int r = 16; r < 40; r++) begin
            op(1, 7, 1, r, st); chk("R3 bad id status", 64'(st), 64'd3);
        end
        op(2, 0, 1, 4095, st); chk("R3 max id status", 64'(st), 64'd3);
        rd(12'h008, 1, d); chk("R3 staging kept", d, 64'h1234);
        op(2, 0, 1, 0, st); rd(12'h008, 1, d); chk("R3 id0 kept", d, 64'(exp_tbl[0][0]));

        // R4: unsupported type with valid flag; ignored without it
        for (int a = 2; a < 8; a++) begin
            op(2, a, 1, 5, st); chk("R4 bad type", 64'(st), 64'd4);
        end
        op(2, 5, 0, 5, st); chk("R4 type ignored when not valid", 64'(st), 64'd1);

        // R5: invalid op codes
        for (int o = 0; o < 32; o++) begin
            if (o >= 1 && o <= 3) continue;
            op(o, 0, 1, 2, st); chk("R5 bad op", 64'(st), 64'd2);
        end

        // R6: bad masks
        wr(12'h008, 64'h0, 1);
        op(1, 1, 1, 7, st); chk("R6 zero mask", 64'(st), 64'd5);
        wr(12'h008, 64'h1_0001, 1);
        op(1, 1, 1, 7, st); chk("R6 bit16 mask", 64'(st), 64'd5);
        wr(12'h008, 64'h8000_0000_0000_0001, 1);
        op(1, 1, 1, 7, st); chk("R6 bit63 mask", 64'(st), 64'd5);
        op(2, 1, 1, 7, st); rd(12'h008, 1, d); chk("R6 table kept", d, 64'(exp_tbl[7][1]));

        // R8: flush changes nothing
        wr(12'h008, 64'hABCD, 1);
        op(3, 1, 1, 7, st); chk("R8 flush status", 64'(st), 64'd1);
        rd(12'h008, 1, d); chk("R8 staging kept", d, 64'hABCD);
        op(2, 1, 1, 7, st); rd(12'h008, 1, d); chk("R8 table kept", d, 64'(exp_tbl[7][1]));

        // R9: back-to-back control write ignored while busy
        wr(12'h008, 64'h00FF, 1);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = ctl(3, 0, 1, 1); bus_wide = 1;
        @(negedge clk);
        bus_wdata = ctl(1, 0, 1, 9);
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        rd(12'h000, 0, d); chk("R9 fields from first write", d, ctl(3, 0, 1, 1));
        op(2, 0, 1, 9, st); rd(12'h008, 1, d); chk("R9 id9 untouched", d, 64'(exp_tbl[9][0]));

        // R10: 32-bit halves
        wr(12'h008, 64'h5A5A, 0);
        wr(12'h00C, 64'hDEADBEEF, 0);
        rd(12'h008, 0, d); chk("R10 low half", d, 64'h5A5A);
        rd(12'h00C, 0, d); chk("R10 high half", d, 64'hDEADBEEF);
        rd(12'h008, 1, d); chk("R10 wide view", d, 64'hDEADBEEF_00005A5A);
        wr(12'h000, ctl(1, 0, 1, 6), 0);
        rd(12'h004, 0, d); chk("R10 narrow start, bad mask", d, 64'h05);
        wr(12'h004, 64'hFFFF_FFFF, 0);
        rd(12'h004, 0, d); chk("R10 upper ctl write ignored", d, 64'h05);
        rd(12'h000, 0, d); chk("R10 ctl low readback", d, ctl(1, 0, 1, 6));

        // R12: capacity-unit word and beyond
        wr(12'h010, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        rd(12'h010, 1, d); chk("R12 unit word zero", d, 64'h0);
        wr(12'h018, 64'h1234_5678, 1);
        rd(12'h018, 1, d); chk("R12 past end zero", d, 64'h0);
        rd(12'hFF8, 1, d); chk("R12 top address zero", d, 64'h0);
        rd(12'h008, 1, d); chk("R12 staging kept", d, 64'hDEADBEEF_00005A5A);

        // R13: staging write in the completion cycle of a load
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = ctl(2, 1, 1, 4); bus_wide = 1;
        @(negedge clk);
        bus_addr = 12'h008; bus_wdata = 64'h1111;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        rd(12'h008, 1, d); chk("R13 load wins", d, 64'(exp_tbl[4][1]));

        done = 1;
        summary();
    end
endmodule